// File: doc/BRIEF.md
# Source Address Match Engine

This block decides whether the sender of a received frame appears in a small on-chip table of known peers. It is used after the frame has passed address filtering. The table is a single 96-byte store that a host fills through a word-wide port. It can be read as twenty-four short entries or as twelve extended entries. A short entry is a 16-bit PAN ID with a 16-bit short address. An extended entry is a 64-bit address that occupies the same space as two short entries. Separate enable vectors select which entries are live.

On a start pulse the engine latches the received address mode and address and walks the table one entry per clock. It then publishes a 24-bit match mask and a 7-bit result index. The index carries the lowest matching position, the entry type and an automatic pending-bit flag. A match-found pulse, when there is a match, is followed one cycle later by a match-done pulse. An entry counts only if its enable bit stays set for the whole walk. Host accesses that land on the word being scanned in that cycle are held off for that cycle.

Top module: `srcm_engine`

## Requirements
- R1: Host word w (0..23) holds table bytes 4w..4w+3, little-endian. Short entry n is word n, with the PAN ID in bits 15:0 and the short address in bits 31:16. Extended entry n is {word 2n+1, word 2n}. A granted read returns the stored word with `host_rvalid` high in the following cycle.
- R2: `ext_en_view` bits 2n and 2n+1 both equal `ext_en` bit 2n. Odd bits of `ext_en` have no effect on the view or on matching.
- R3: In short mode (`addr_mode` = 2'b10), mask bit n is set when short enable bit n is set and entry n's PAN ID and short address both equal the received values.
- R4: In extended mode (`addr_mode` = 2'b11), for each enabled extended entry n (enable bit 2n) that equals the 64-bit received address, mask bits 2n and 2n+1 are set.
- R5: With no match, the index is 7'h3F. Otherwise bits 4:0 hold the lowest matching entry number, bit 5 is 0 for short and 1 for extended, and bit 6 is the pending flag.
- R6: The pending flag is `autopend_en` (sampled at start) AND "any match". It is 0 when there is no match.
- R7: A start is ignored when `match_en` or `frame_ok` is low, or while the engine is busy. No pulses are produced and the results hold.
- R8: Counting the sampling edge of start as edge 0, short-mode results update and match-found rises at edge 25, with match-done at edge 26. In extended mode these are edges 13 and 14. Match-found is followed by match-done on the next cycle, and each is a one-cycle pulse.
- R9: An entry whose enable bit is low in any cycle of the walk (from start to publication) is excluded from the mask and the index.
- R10: During a walk, a host request to a word the scan reads in that cycle gets `host_gnt` low. A request to any other word is granted.
- R11: Address mode 2'b00 (none) or 2'b01 (reserved) gives mask 0 and index 7'h3F. Match-done comes at edge 2 with no match-found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Table word index |
| host_wdata | input | 32 | Write data |
| host_gnt | output | 1 | Request accepted this cycle |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| short_en | input | 24 | Short entry enables |
| ext_en | input | 24 | Extended entry enables (bit 2n = entry n) |
| ext_en_view | output | 24 | Extended enables with pairs duplicated |
| match_en | input | 1 | Matching enabled |
| autopend_en | input | 1 | Automatic pending flag enabled |
| start | input | 1 | Start pulse for an accepted frame |
| frame_ok | input | 1 | Frame passed filtering |
| addr_mode | input | 2 | Source address mode of the frame |
| rx_pan | input | 16 | Received source PAN ID |
| rx_short | input | 16 | Received short source address |
| rx_ext | input | 64 | Received extended source address |
| busy | output | 1 | Walk in progress |
| res_mask | output | 24 | Match mask |
| res_index | output | 7 | Result index |
| match_found | output | 1 | Pulse: at least one match |
| match_done | output | 1 | Pulse: walk complete |

## Verification
A start is sampled at edge 0. The engine visits entry k between edges k and k+1. Results and match-found are registered one edge after the last entry: edge 25 for short mode, edge 13 for extended mode and edge 1 for mode none. Match-done follows one edge later. The bench drives inputs on falling edges and records, at each falling edge after edge k, the index k at which each pulse appears, then compares it to these numbers. Host read data is checked one edge after the grant. Grant during a walk is probed half a cycle after edge k, when the scan sits on word k.

// File: rtl/srcm_pkg.sv
package srcm_pkg;
  parameter int unsigned SRCM_SHORT = 24;
  localparam int unsigned SRCM_EXT = SRCM_SHORT / 2;
  localparam int unsigned SRCM_IW  = $clog2(SRCM_SHORT);
  localparam int unsigned SRCM_DW  = 32;
  localparam logic [6:0]  SRCM_NONE = 7'h3F;

  typedef enum logic [1:0] {
    AM_NONE  = 2'b00,
    AM_RSVD  = 2'b01,
    AM_SHORT = 2'b10,
    AM_EXT   = 2'b11
  } addr_mode_e;

  // Copy every even bit onto its odd neighbour.
  function automatic logic [SRCM_SHORT-1:0] pair_dup(input logic [SRCM_SHORT-1:0] v);
    logic [SRCM_SHORT-1:0] r;
    r = '0;
    for (int n = 0; n < int'(SRCM_EXT); n++) begin
      r[2*n]   = v[2*n];
      r[2*n+1] = v[2*n];
    end
    return r;
  endfunction

  // Pack the lowest set position, type and pending flag.
  function automatic logic [6:0] pack_index(input logic [SRCM_SHORT-1:0] m,
                                            input logic is_ext, input logic ap);
    logic [6:0] r;
    int pos;
    r = SRCM_NONE;
    for (int n = int'(SRCM_SHORT) - 1; n >= 0; n--) begin
      if (m[n]) begin
        pos = is_ext ? n / 2 : n;
        r = {ap, is_ext, 5'(pos)};
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/srcm_table.sv
module srcm_table
  import srcm_pkg::*;
#(
  parameter int unsigned WORDS = SRCM_SHORT,
  parameter int unsigned DW    = SRCM_DW,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_gnt,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  input  logic          scan_active,
  input  logic [AW-1:0] scan_wa,
  input  logic [AW-1:0] scan_wb,
  output logic [DW-1:0] scan_da,
  output logic [DW-1:0] scan_db
);
  logic [DW-1:0] mem [WORDS];
  logic collide;
  logic addr_ok;

  assign addr_ok  = int'(host_addr) < int'(WORDS);
  assign collide  = scan_active && host_req &&
                    ((host_addr == scan_wa) || (host_addr == scan_wb));
  assign host_gnt = host_req && !collide;

  assign scan_da = (int'(scan_wa) < int'(WORDS)) ? mem[scan_wa] : '0;
  assign scan_db = (int'(scan_wb) < int'(WORDS)) ? mem[scan_wb] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) mem[i] <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= host_gnt && !host_we;
      if (host_gnt && host_we && addr_ok) mem[host_addr] <= host_wdata;
      if (host_gnt && !host_we) host_rdata <= addr_ok ? mem[host_addr] : '0;
    end
  end

  // R1: read data follows a granted read by one cycle
  assert_rvalid_after_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && !host_we) |=> host_rvalid);
  // R10: a write that is held off leaves the scanned word untouched
  assert_blocked_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_active && host_req && host_we && host_addr == scan_wa) |=>
      (mem[$past(scan_wa)] == $past(scan_da)));
endmodule

// File: rtl/srcm_en_view.sv
module srcm_en_view
  import srcm_pkg::*;
#(
  parameter int unsigned N = SRCM_SHORT
) (
  input  logic [N-1:0] ext_en,
  output logic [N-1:0] ext_en_view
);
  for (genvar g = 0; g < int'(N / 2); g++) begin : g_pair
    assign ext_en_view[2*g]   = ext_en[2*g];
    assign ext_en_view[2*g+1] = ext_en[2*g];
  end
endmodule

// File: rtl/srcm_scan.sv
module srcm_scan
  import srcm_pkg::*;
#(
  parameter int unsigned N  = SRCM_SHORT,
  parameter int unsigned DW = SRCM_DW,
  localparam int unsigned NE = N / 2,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          frame_ok,
  input  logic          match_en,
  input  logic          autopend_en,
  input  logic [1:0]    addr_mode,
  input  logic [15:0]   rx_pan,
  input  logic [15:0]   rx_short,
  input  logic [63:0]   rx_ext,
  input  logic [N-1:0]  short_en,
  input  logic [N-1:0]  ext_en,
  output logic          scan_active,
  output logic [IW-1:0] scan_wa,
  output logic [IW-1:0] scan_wb,
  input  logic [DW-1:0] scan_da,
  input  logic [DW-1:0] scan_db,
  output logic          busy,
  output logic [N-1:0]  res_mask,
  output logic [6:0]    res_index,
  output logic          match_found,
  output logic          match_done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PUB, ST_DONE} st_e;

  st_e           state;
  addr_mode_e    mode_q;
  logic [15:0]   pan_q, sh_q;
  logic [63:0]   ext_q;
  logic          ap_q;
  logic [IW-1:0] idx_q;
  logic [N-1:0]  alive_q, raw_q;

  logic          is_ext, run_now, pub_now, accept;
  logic [N-1:0]  sel_now, hit_vec, keep, fin_mask;
  logic [IW-1:0] bitpos, last_idx;
  logic          entry_eq, entry_live, scan_hit;

  assign accept  = (state == ST_IDLE) && start && match_en && frame_ok;
  assign run_now = (state == ST_RUN);
  assign pub_now = (state == ST_PUB);

  always_comb begin
    is_ext     = (mode_q == AM_EXT);
    sel_now    = is_ext ? ext_en : short_en;
    bitpos     = is_ext ? {idx_q[IW-2:0], 1'b0} : idx_q;
    hit_vec    = is_ext ? (N'(3) << bitpos) : (N'(1) << bitpos);
    entry_eq   = is_ext ? ({scan_db, scan_da} == ext_q) : (scan_da == {sh_q, pan_q});
    entry_live = alive_q[bitpos] && sel_now[bitpos];
    scan_hit   = run_now && entry_live && entry_eq;
    last_idx   = is_ext ? IW'(NE - 1) : IW'(N - 1);
    keep       = is_ext ? pair_dup(alive_q & sel_now) : (alive_q & sel_now);
    fin_mask   = raw_q & keep;
  end

  assign scan_active = run_now;
  assign scan_wa     = is_ext ? bitpos : idx_q;
  assign scan_wb     = is_ext ? bitpos + IW'(1) : idx_q;
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mode_q      <= AM_NONE;
      pan_q       <= '0;
      sh_q        <= '0;
      ext_q       <= '0;
      ap_q        <= 1'b0;
      idx_q       <= '0;
      alive_q     <= '0;
      raw_q       <= '0;
      res_mask    <= '0;
      res_index   <= SRCM_NONE;
      match_found <= 1'b0;
      match_done  <= 1'b0;
    end else begin
      match_found <= 1'b0;
      match_done  <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          mode_q  <= addr_mode_e'(addr_mode);
          pan_q   <= rx_pan;
          sh_q    <= rx_short;
          ext_q   <= rx_ext;
          ap_q    <= autopend_en;
          idx_q   <= '0;
          raw_q   <= '0;
          alive_q <= (addr_mode == AM_EXT) ? ext_en : short_en;
          state   <= (addr_mode == AM_SHORT || addr_mode == AM_EXT) ? ST_RUN : ST_PUB;
        end
        ST_RUN: begin
          if (scan_hit) raw_q <= raw_q | hit_vec;
          alive_q <= alive_q & sel_now;
          idx_q   <= idx_q + IW'(1);
          if (idx_q == last_idx) state <= ST_PUB;
        end
        ST_PUB: begin
          res_mask    <= fin_mask;
          res_index   <= pack_index(fin_mask, is_ext, ap_q && (|fin_mask));
          match_found <= |fin_mask;
          state       <= ST_DONE;
        end
        default: begin
          match_done <= 1'b1;
          state      <= ST_IDLE;
        end
      endcase
    end
  end

  // R8: done follows found one cycle later, both single-cycle
  assert_found_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_found |=> match_done);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_done |=> !match_done);
  // R5: index is the no-match code exactly when the mask is empty
  assert_index_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_done |-> ((res_mask == '0) == (res_index == SRCM_NONE)));
  // R6: pending flag never set without a match
  assert_pend_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_mask == '0) |-> !res_index[6]);
  // R4: extended results always set whole pairs
  assert_ext_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_done && res_index[5] && res_index != SRCM_NONE) |-> (res_mask == pair_dup(res_mask)));
  // R7: results change only when publishing
  assert_results_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pub_now |=> ($stable(res_mask) && $stable(res_index)));
  assert_gated_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !(match_en && frame_ok)) |=> !busy);
  // R9: a bit disabled in the publish cycle cannot appear in the mask
  assert_live_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pub_now && !is_ext) |=> ((res_mask & ~$past(short_en)) == '0));
endmodule

// File: rtl/srcm_engine.sv
module srcm_engine
  import srcm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [4:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic        host_gnt,
  output logic        host_rvalid,
  output logic [31:0] host_rdata,
  input  logic [23:0] short_en,
  input  logic [23:0] ext_en,
  output logic [23:0] ext_en_view,
  input  logic        match_en,
  input  logic        autopend_en,
  input  logic        start,
  input  logic        frame_ok,
  input  logic [1:0]  addr_mode,
  input  logic [15:0] rx_pan,
  input  logic [15:0] rx_short,
  input  logic [63:0] rx_ext,
  output logic        busy,
  output logic [23:0] res_mask,
  output logic [6:0]  res_index,
  output logic        match_found,
  output logic        match_done
);
  localparam int unsigned AW = $clog2(SRCM_SHORT);

  logic          scan_active;
  logic [AW-1:0] scan_wa, scan_wb;
  logic [31:0]   scan_da, scan_db;

  srcm_table #(.WORDS(SRCM_SHORT), .DW(SRCM_DW)) table_i (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_gnt(host_gnt),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .scan_active(scan_active), .scan_wa(scan_wa), .scan_wb(scan_wb),
    .scan_da(scan_da), .scan_db(scan_db)
  );

  srcm_en_view #(.N(SRCM_SHORT)) view_i (
    .ext_en(ext_en), .ext_en_view(ext_en_view)
  );

  srcm_scan #(.N(SRCM_SHORT), .DW(SRCM_DW)) scan_i (
    .clk(clk), .rst_n(rst_n),
    .start(start), .frame_ok(frame_ok), .match_en(match_en),
    .autopend_en(autopend_en), .addr_mode(addr_mode),
    .rx_pan(rx_pan), .rx_short(rx_short), .rx_ext(rx_ext),
    .short_en(short_en), .ext_en(ext_en),
    .scan_active(scan_active), .scan_wa(scan_wa), .scan_wb(scan_wb),
    .scan_da(scan_da), .scan_db(scan_db),
    .busy(busy), .res_mask(res_mask), .res_index(res_index),
    .match_found(match_found), .match_done(match_done)
  );

  // R2: view always carries whole pairs
  assert_view_pairs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en_view[1] == ext_en_view[0]);
endmodule

// File: tb/srcm_engine_tb.sv
`timescale 1ns/1ps
module srcm_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 0, host_we = 0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_gnt, host_rvalid;
  logic [31:0] host_rdata;
  logic [23:0] short_en = '0, ext_en = '0, ext_en_view;
  logic        match_en = 1, autopend_en = 0, start = 0, frame_ok = 1;
  logic [1:0]  addr_mode = 2'b00;
  logic [15:0] rx_pan = '0, rx_short = '0;
  logic [63:0] rx_ext = '0;
  logic        busy, match_found, match_done;
  logic [23:0] res_mask;
  logic [6:0]  res_index;

  int tests = 0, fails = 0;
  logic [31:0] shadow [24];

  // outputs of the watch task
  int   f_at, d_at;
  logic any_busy, col_a, col_b;

  always #5 clk = ~clk;

  srcm_engine dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 5'(a); host_wdata = d;
    @(posedge clk); #1;
    host_req = 0; host_we = 0;
    shadow[a] = d;
  endtask

  task automatic host_read(input int a, output logic [31:0] d, output logic v);
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = 5'(a);
    @(posedge clk); #1;
    host_req = 0;
    d = host_rdata; v = host_rvalid;
  endtask

  // bench model of the table matching
  function automatic logic [23:0] model_mask(input logic [1:0] m, input logic [23:0] en);
    logic [23:0] r = '0;
    if (m == 2'b10) begin
      for (int n = 0; n < 24; n++)
        if (en[n] && shadow[n][15:0] == rx_pan && shadow[n][31:16] == rx_short) r[n] = 1;
    end else if (m == 2'b11) begin
      for (int n = 0; n < 12; n++)
        if (en[2*n] && {shadow[2*n+1], shadow[2*n]} == rx_ext) begin
          r[2*n] = 1; r[2*n+1] = 1;
        end
    end
    return r;
  endfunction

  function automatic logic [6:0] model_index(input logic [23:0] m, input bit ext, input bit ap);
    for (int n = 0; n < 24; n++)
      if (m[n]) return {ap, ext, ext ? 5'(n / 2) : 5'(n)};
    return 7'h3F;
  endfunction

  // start a walk and record pulse positions relative to start edge 0
  task automatic watch(input logic [1:0] m, input int dis_k, input int dis_bit, input int col_k);
    f_at = -1; d_at = -1; any_busy = 0; col_a = 1'bx; col_b = 1'bx;
    @(negedge clk);
    addr_mode = m; start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k <= 40; k++) begin
      if (match_found && f_at < 0) f_at = k;
      if (match_done && d_at < 0) d_at = k;
      any_busy |= busy;
      if (k == dis_k) short_en[dis_bit] = 1'b0;
      if (k == dis_k + 1) short_en[dis_bit] = 1'b1;
      if (k == col_k) begin
        host_req = 1; host_we = 0; host_addr = 5'(k);
        #1 col_a = host_gnt;
        host_addr = 5'(k + 1);
        #1 col_b = host_gnt;
        host_req = 0;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(res_mask == 0, "R5", "reset mask", res_mask, 0);
    check(res_index == 7'h3F, "R5", "reset index", res_index, 7'h3F);
    check(!busy && !match_found && !match_done, "R8", "reset idle",
          {busy, match_found, match_done}, 0);
  endtask

  task automatic t_host_rw();
    logic [31:0] d; logic v;
    host_write(20, 32'hDEADBEEF);
    host_read(20, d, v);
    check(v, "R1", "rvalid after read", v, 1);
    check(d == 32'hDEADBEEF, "R1", "read back", d, 32'hDEADBEEF);
  endtask

  task automatic t_view();
    @(negedge clk); ext_en = 24'h000001; #1;
    check(ext_en_view == 24'h000003, "R2", "even bit pair", ext_en_view, 24'h3);
    ext_en = 24'h000002; #1;
    check(ext_en_view == 24'h000000, "R2", "odd bit ignored", ext_en_view, 0);
    ext_en = '0;
  endtask

  task automatic load_short();
    host_write(2, 32'h1111_5555);
    host_write(3, 32'h1234_ABCD);
    host_write(7, 32'h1234_ABCD);
    host_write(9, 32'h1234_ABCD);
  endtask

  task automatic t_short();
    logic [23:0] em;
    load_short();
    short_en = 24'h00008C; autopend_en = 1; rx_pan = 16'hABCD; rx_short = 16'h1234;
    em = model_mask(2'b10, short_en);
    watch(2'b10, -1, 0, -1);
    check(res_mask == em, "R3", "short mask", res_mask, em);
    check(res_index == model_index(em, 0, 1), "R5", "short index", res_index, model_index(em, 0, 1));
    check(res_index[6], "R6", "pending set on match", res_index[6], 1);
    check(f_at == 25, "R8", "short found edge", f_at, 25);
    check(d_at == 26, "R8", "short done edge", d_at, 26);
    autopend_en = 0;
  endtask

  task automatic t_ext();
    logic [23:0] em;
    host_write(2, 32'h89AB_CDEF); host_write(3, 32'h0123_4567);
    host_write(10, 32'h89AB_CDEF); host_write(11, 32'h0123_4567);
    ext_en = 24'h000484; rx_ext = 64'h0123_4567_89AB_CDEF;
    em = model_mask(2'b11, ext_en);
    watch(2'b11, -1, 0, -1);
    check(res_mask == em, "R4", "ext mask", res_mask, em);
    check(res_index == model_index(em, 1, 0), "R5", "ext index", res_index, model_index(em, 1, 0));
    check(!res_index[6], "R6", "pending off when disabled", res_index[6], 0);
    check(f_at == 13 && d_at == 14, "R8", "ext pulse edges", {f_at[15:0], d_at[15:0]}, {16'd13, 16'd14});
    ext_en = '0;
  endtask

  task automatic t_nomatch_collide();
    rx_pan = 16'hABCD; rx_short = 16'h9999; short_en = 24'hFFFFFF; autopend_en = 1;
    watch(2'b10, -1, 0, 5);
    check(res_mask == 0 && res_index == 7'h3F, "R5", "no match result", {res_mask, res_index}, {24'h0, 7'h3F});
    check(f_at == -1 && d_at == 26, "R8", "no found, done at 26", d_at, 26);
    check(col_a === 1'b0, "R10", "grant on scanned word", col_a, 0);
    check(col_b === 1'b1, "R10", "grant on other word", col_b, 1);
    autopend_en = 0;
  endtask

  task automatic t_disable_mid();
    logic [23:0] em;
    load_short();
    short_en = 24'h00008C; rx_pan = 16'hABCD; rx_short = 16'h1234;
    em = model_mask(2'b10, 24'h000084);
    watch(2'b10, 10, 3, -1);
    check(res_mask == em, "R9", "dropped entry excluded", res_mask, em);
    check(res_index == model_index(em, 0, 0), "R9", "index skips dropped", res_index, model_index(em, 0, 0));
  endtask

  task automatic t_none();
    watch(2'b00, -1, 0, -1);
    check(res_mask == 0 && res_index == 7'h3F, "R11", "mode none result", res_index, 7'h3F);
    check(f_at == -1 && d_at == 2, "R11", "mode none done edge", d_at, 2);
    watch(2'b01, -1, 0, -1);
    check(d_at == 2 && res_index == 7'h3F, "R11", "reserved mode", d_at, 2);
  endtask

  task automatic t_ignored();
    logic [23:0] m0; logic [6:0] i0;
    load_short();
    short_en = 24'h00008C; rx_pan = 16'hABCD; rx_short = 16'h1234;
    watch(2'b11, -1, 0, -1);
    m0 = res_mask; i0 = res_index;
    match_en = 0;
    watch(2'b10, -1, 0, -1);
    check(!any_busy && d_at == -1 && f_at == -1, "R7", "match_en low ignored", any_busy, 0);
    check(res_mask == m0 && res_index == i0, "R7", "results hold", res_mask, m0);
    match_en = 1; frame_ok = 0;
    watch(2'b10, -1, 0, -1);
    check(!any_busy && d_at == -1, "R7", "frame_ok low ignored", any_busy, 0);
    frame_ok = 1;
  endtask

  initial begin
    for (int i = 0; i < 24; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_host_rw();
    t_view();
    t_short();
    t_ext();
    t_nomatch_collide();
    t_disable_mid();
    t_none();
    t_ignored();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule